// File: doc/BRIEF.md
# Parallel Display Bus Timing Engine

This block drives an asynchronous 8080-style parallel bus toward a display controller that holds its own frame memory. For each access the host asks for, it draws chip-select, write-strobe and read-strobe pulses whose edges sit at programmed tick offsets from the start of that access. It then keeps chip-select high for a programmed gap before the next access may begin. Three access types exist: command write, parameter/data write and register read. The data bus carries 8 or 16 bits per bus cycle.

The host side is a single request port. While the engine is idle, a request is taken in the same clock it is presented, and `reqAck` marks that clock. Read data comes back with a one-clock `rdValid` pulse once the read bus cycle has finished. Every timing value arrives already expressed in ticks and must stay stable while an access is in flight. A tick is either one clock or two clocks, chosen by one configuration bit. The bidirectional data bus appears as separate output, output-enable and input vectors.

Top module: `dbus_engine`

## Requirements
- R1: After reset, `csN`, `wrN` and `rdN` are high, `busOe` is low, `busy` is low and `rdValid` is low.
- R2: Let clock 0 be the first clock after the accepting edge, and let a tick last D clocks (D is 1, or 2 when `cfgDiv2`=1). Pins in clock c≥1 show tick t=(c−1)/D, rounded down, while t is below the access length L. `csN` is low exactly for ticks with `cfgCsOn` ≤ t < `cfgCsOff`.
- R3: On a write, `wrN` is low exactly for ticks `cfgWrOn` ≤ t < `cfgWrOff`, and `rdN` stays high.
- R4: On a read, `rdN` is low exactly for ticks `cfgRdOn` ≤ t < `cfgRdOff`, `wrN` stays high and `busOe` stays low.
- R5: L is the larger of `cfgCsOff` and the cycle length of the access type (`cfgRdCycle` for reads, `cfgWrCycle` for writes). `busy` is high from clock 0 through clock (L+`cfgCsGap`)·D−1. `reqAck` equals `reqValid` whenever `busy` is low.
- R6: With `cfgDiv2`=1, every tick offset in R2 to R5 and R9 to R11 is stretched to two clocks.
- R7: `dcSel` is low for a command write (`reqKind`=2'b00) and high for a data write (2'b01) and for a read (`reqKind[1]`=1). It holds its value for the whole time `csN` is low.
- R8: With `cfgWide`=0, `busOut[15:8]` is zero during writes, and read data is the low byte of the bus, zero-extended.
- R9: A read captures `busIn` as driven during clock `cfgAccess`·D+1, the first clock in which the pins show tick `cfgAccess`. `cfgAccess` must be below L.
- R10: `rdValid` is a single-clock pulse in clock L·D+1 of a read. `rdData` holds the captured word.
- R11: On a write, `busOe` is high and `busOut` carries the request's write data in clocks 1 through L·D.
- R12: A request presented while `busy` is high is ignored. It gets no `reqAck` and starts no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgCsOn | input | 4 | Chip-select assert tick |
| cfgCsOff | input | 6 | Chip-select deassert tick |
| cfgWrOn | input | 4 | Write-strobe assert tick |
| cfgWrOff | input | 6 | Write-strobe deassert tick |
| cfgRdOn | input | 4 | Read-strobe assert tick |
| cfgRdOff | input | 6 | Read-strobe deassert tick |
| cfgWrCycle | input | 6 | Write cycle length in ticks |
| cfgRdCycle | input | 6 | Read cycle length in ticks |
| cfgCsGap | input | 6 | Minimum chip-select high gap after an access, in ticks |
| cfgAccess | input | 6 | Read sample tick |
| cfgDiv2 | input | 1 | 1: tick is two clocks |
| cfgWide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| reqValid | input | 1 | Access request |
| reqKind | input | 2 | 00 command write, 01 data write, 1x read |
| reqWdata | input | 16 | Write data |
| reqAck | output | 1 | Request taken this clock |
| busy | output | 1 | Access or gap in progress |
| rdData | output | 16 | Last read word |
| rdValid | output | 1 | Read word ready pulse |
| csN | output | 1 | Chip select, active low |
| wrN | output | 1 | Write strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| dcSel | output | 1 | Low for command, high for data |
| busOut | output | 16 | Bus drive value |
| busOe | output | 1 | Bus drive enable |
| busIn | input | 16 | Bus receive value |

## Verification
The bench sweeps both tick rates, both bus widths, all three access types and several timing sets. The sets include a zero gap and a chip-select deassert later than the cycle length, and every pin is compared in every clock of every access. An off-by-one in the tick counter, or a divider that is not realigned at the start of an access, shows up as a strobe edge one clock or one tick out of place. A sample point one clock early or late is caught because `busIn` changes every clock, so the captured word names the clock in which it was taken. An access length that ignores the chip-select deassert would drop `busy` early and cut `csN` short. A request taken while busy would show up as an extra strobe pulse inside the window.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ACCESS, PH_GAP} phase_e;

  // Per-clock commands from control to datapath
  typedef struct packed {
    logic load;     // request taken this clock
    logic isRead;   // type of the request being taken
    logic csAct;    // chip select active in the current tick
    logic wrAct;    // write strobe active
    logic rdAct;    // read strobe active
    logic oeAct;    // drive the bus
    logic sample;   // first clock of the sample tick
    logic done;     // last clock of a read access
  } strobe_t;
endpackage

// File: rtl/dbus_ctrl.sv
module dbus_ctrl
  import dbus_pkg::*;
#(
  parameter int ON_W  = 4,
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ON_W-1:0]  cfgCsOn,
  input  logic [OFF_W-1:0] cfgCsOff,
  input  logic [ON_W-1:0]  cfgWrOn,
  input  logic [OFF_W-1:0] cfgWrOff,
  input  logic [ON_W-1:0]  cfgRdOn,
  input  logic [OFF_W-1:0] cfgRdOff,
  input  logic [OFF_W-1:0] cfgWrCycle,
  input  logic [OFF_W-1:0] cfgRdCycle,
  input  logic [OFF_W-1:0] cfgCsGap,
  input  logic [OFF_W-1:0] cfgAccess,
  input  logic             cfgDiv2,
  input  logic             reqValid,
  input  logic             reqRead,
  output logic             reqAck,
  output logic             busy,
  output strobe_t          st
);
  localparam int PAD_W = OFF_W - ON_W;

  phase_e           phase;
  logic [OFF_W-1:0] tickCnt;
  logic             preDiv;
  logic             isRdQ;

  logic [OFF_W-1:0] csOnX, wrOnX, rdOnX;
  logic [OFF_W-1:0] cycLen, accLen;
  logic             tickEn, lastTick, lastGap, inAcc, firstClk;

  assign csOnX = {{PAD_W{1'b0}}, cfgCsOn};
  assign wrOnX = {{PAD_W{1'b0}}, cfgWrOn};
  assign rdOnX = {{PAD_W{1'b0}}, cfgRdOn};

  assign cycLen   = isRdQ ? cfgRdCycle : cfgWrCycle;
  assign accLen   = (cfgCsOff > cycLen) ? cfgCsOff : cycLen;
  assign tickEn   = !cfgDiv2 || preDiv;
  assign firstClk = !cfgDiv2 || !preDiv;
  assign lastTick = (tickCnt == accLen - 1'b1);
  assign lastGap  = (tickCnt == cfgCsGap - 1'b1);
  assign inAcc    = (phase == PH_ACCESS);

  assign reqAck = (phase == PH_IDLE) && reqValid;
  assign busy   = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      preDiv  <= 1'b0;
      isRdQ   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase   <= PH_ACCESS;
            tickCnt <= '0;
            preDiv  <= 1'b0;
            isRdQ   <= reqRead;
          end
        end
        PH_ACCESS: begin
          preDiv <= ~preDiv;
          if (tickEn) begin
            if (lastTick) begin
              tickCnt <= '0;
              phase   <= (cfgCsGap == '0) ? PH_IDLE : PH_GAP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        PH_GAP: begin
          preDiv <= ~preDiv;
          if (tickEn) begin
            if (lastGap) begin
              tickCnt <= '0;
              phase   <= PH_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    st        = '0;
    st.load   = reqAck;
    st.isRead = reqRead;
    st.csAct  = inAcc && (tickCnt >= csOnX) && (tickCnt < cfgCsOff);
    st.wrAct  = inAcc && !isRdQ && (tickCnt >= wrOnX) && (tickCnt < cfgWrOff);
    st.rdAct  = inAcc && isRdQ && (tickCnt >= rdOnX) && (tickCnt < cfgRdOff);
    st.oeAct  = inAcc && !isRdQ;
    st.sample = inAcc && isRdQ && firstClk && (tickCnt == cfgAccess);
    st.done   = inAcc && isRdQ && tickEn && lastTick;
  end
endmodule

// File: rtl/dbus_datapath.sv
module dbus_datapath
  import dbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgWide,
  input  logic [DATA_W-1:0] busIn,
  output logic              csN,
  output logic              wrN,
  output logic              rdN,
  output logic              dcSel,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int NARROW_W = DATA_W / 2;
  localparam int UPPER_W  = DATA_W - NARROW_W;

  logic [DATA_W-1:0] wrWord, rdWord;
  logic              sampleDly, rdPend;

  // Narrow mode keeps only the low lane, upper lane forced to zero
  assign wrWord = cfgWide ? reqWdata : {{UPPER_W{1'b0}}, reqWdata[NARROW_W-1:0]};
  assign rdWord = cfgWide ? busIn    : {{UPPER_W{1'b0}}, busIn[NARROW_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN       <= 1'b1;
      wrN       <= 1'b1;
      rdN       <= 1'b1;
      busOe     <= 1'b0;
      dcSel     <= 1'b1;
      busOut    <= '0;
      rdData    <= '0;
      sampleDly <= 1'b0;
      rdPend    <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      csN       <= ~st.csAct;
      wrN       <= ~st.wrAct;
      rdN       <= ~st.rdAct;
      busOe     <= st.oeAct;
      sampleDly <= st.sample;
      rdPend    <= st.done;
      rdValid   <= rdPend;
      if (st.load) begin
        dcSel <= reqKind[1] | reqKind[0];
        if (!st.isRead) busOut <= wrWord;
      end
      if (sampleDly) rdData <= rdWord;
    end
  end
endmodule

// File: rtl/dbus_engine.sv
module dbus_engine
  import dbus_pkg::*;
#(
  parameter int ON_W   = 4,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ON_W-1:0]   cfgCsOn,
  input  logic [OFF_W-1:0]  cfgCsOff,
  input  logic [ON_W-1:0]   cfgWrOn,
  input  logic [OFF_W-1:0]  cfgWrOff,
  input  logic [ON_W-1:0]   cfgRdOn,
  input  logic [OFF_W-1:0]  cfgRdOff,
  input  logic [OFF_W-1:0]  cfgWrCycle,
  input  logic [OFF_W-1:0]  cfgRdCycle,
  input  logic [OFF_W-1:0]  cfgCsGap,
  input  logic [OFF_W-1:0]  cfgAccess,
  input  logic              cfgDiv2,
  input  logic              cfgWide,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              csN,
  output logic              wrN,
  output logic              rdN,
  output logic              dcSel,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] busIn
);
  strobe_t st;

  dbus_ctrl #(.ON_W(ON_W), .OFF_W(OFF_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgCsOn(cfgCsOn), .cfgCsOff(cfgCsOff),
    .cfgWrOn(cfgWrOn), .cfgWrOff(cfgWrOff),
    .cfgRdOn(cfgRdOn), .cfgRdOff(cfgRdOff),
    .cfgWrCycle(cfgWrCycle), .cfgRdCycle(cfgRdCycle),
    .cfgCsGap(cfgCsGap), .cfgAccess(cfgAccess), .cfgDiv2(cfgDiv2),
    .reqValid(reqValid), .reqRead(reqKind[1]),
    .reqAck(reqAck), .busy(busy), .st(st)
  );

  dbus_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .reqKind(reqKind), .reqWdata(reqWdata), .cfgWide(cfgWide), .busIn(busIn),
    .csN(csN), .wrN(wrN), .rdN(rdN), .dcSel(dcSel),
    .busOut(busOut), .busOe(busOe), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/dbus_engine_chk.sv
module dbus_engine_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic wrN,
  input logic rdN,
  input logic dcSel,
  input logic busOe,
  input logic busy,
  input logic reqAck,
  input logic rdValid
);
  // R7: command/data select cannot move while chip select is held low
  a_r7_dc_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> $stable(dcSel));

  // R12: nothing is taken while an access or gap is running
  a_r12_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqAck);

  // R4: the bus is never driven while the read strobe is low
  a_r4_no_drive_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busOe);

  // R3: the two strobes are never low together
  a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!wrN && !rdN));

  // R10: read completion is a single-clock pulse
  a_r10_rdvalid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R5: pins are quiet once the engine has been idle for a full clock
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> (csN && wrN && rdN && !busOe));
endmodule

bind dbus_engine dbus_engine_chk i_chk (.*);

// File: tb/test_dbus_engine.sv
module test_dbus_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgCsOn, cfgWrOn, cfgRdOn;
  logic [5:0]  cfgCsOff, cfgWrOff, cfgRdOff, cfgWrCycle, cfgRdCycle, cfgCsGap, cfgAccess;
  logic        cfgDiv2, cfgWide;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic [15:0] reqWdata, busIn;
  logic        reqAck, busy, rdValid, csN, wrN, rdN, dcSel, busOe;
  logic [15:0] rdData, busOut;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbus_engine i_dbus_engine (
    .clk(clk), .rstN(rstN),
    .cfgCsOn(cfgCsOn), .cfgCsOff(cfgCsOff), .cfgWrOn(cfgWrOn), .cfgWrOff(cfgWrOff),
    .cfgRdOn(cfgRdOn), .cfgRdOff(cfgRdOff), .cfgWrCycle(cfgWrCycle), .cfgRdCycle(cfgRdCycle),
    .cfgCsGap(cfgCsGap), .cfgAccess(cfgAccess), .cfgDiv2(cfgDiv2), .cfgWide(cfgWide),
    .reqValid(reqValid), .reqKind(reqKind), .reqWdata(reqWdata),
    .reqAck(reqAck), .busy(busy), .rdData(rdData), .rdValid(rdValid),
    .csN(csN), .wrN(wrN), .rdN(rdN), .dcSel(dcSel),
    .busOut(busOut), .busOe(busOe), .busIn(busIn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input int c);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s clock %0d: actual=%0h expected=%0h", req, c, act, exp);
    end
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic setCfg(input int i);
    cfgCsOn    = 4'(i);
    cfgWrOn    = 4'(i + 1);
    cfgWrOff   = 6'(i + 2 + i);
    cfgRdOn    = 4'(i);
    cfgRdOff   = 6'(i + 2);
    cfgAccess  = 6'(i + 1 + (i % 2));
    cfgWrCycle = 6'(int'(cfgWrOff) + (i % 3));
    cfgRdCycle = 6'(int'(cfgRdOff) + i);
    cfgCsOff   = 6'(maxi(int'(cfgWrOff), int'(cfgRdOff)) + ((i == 2) ? 3 : 0));
    cfgCsGap   = 6'(i);
  endtask

  task automatic runAccess(input int kind, input logic [15:0] data);
    int d, len, win, expRd;
    bit isRd;
    logic [15:0] expBus;
    d    = cfgDiv2 ? 2 : 1;
    isRd = (kind == 2);
    len  = maxi(isRd ? int'(cfgRdCycle) : int'(cfgWrCycle), int'(cfgCsOff));
    win  = maxi((len + int'(cfgCsGap)) * d, len * d + 2) + 1;
    expBus = cfgWide ? data : {8'h00, data[7:0]};
    reqValid = 1'b1;
    reqKind  = 2'(kind);
    reqWdata = data;
    #1;
    chk("R5 ack when idle", 32'(reqAck), 32'd1, -1);
    chk("R5 idle before", 32'(busy), 32'd0, -1);
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = ~data;
    for (int c = 0; c <= win; c++) begin
      int t;
      bit act;
      busIn = 16'h5A00 + 16'(c);
      if (c == 1) begin
        reqValid = 1'b1;
        reqKind  = 2'b01;
      end
      if (c == 2) reqValid = 1'b0;
      #1;
      if (c == 1) chk("R12 no ack while busy", 32'(reqAck), 32'd0, c);
      t   = (c >= 1) ? (c - 1) / d : 0;
      act = (c >= 1) && ((c - 1) < len * d);
      chk(d == 2 ? "R6 csN" : "R2 csN", 32'(csN),
          32'(!(act && t >= int'(cfgCsOn) && t < int'(cfgCsOff))), c);
      chk("R3 wrN", 32'(wrN),
          32'(!(act && !isRd && t >= int'(cfgWrOn) && t < int'(cfgWrOff))), c);
      chk("R4 rdN", 32'(rdN),
          32'(!(act && isRd && t >= int'(cfgRdOn) && t < int'(cfgRdOff))), c);
      chk(isRd ? "R4 busOe" : "R11 busOe", 32'(busOe), 32'(act && !isRd), c);
      chk("R5 busy", 32'(busy), 32'(c < (len + int'(cfgCsGap)) * d), c);
      chk("R10 rdValid", 32'(rdValid), 32'(isRd && c == len * d + 1), c);
      if (act) chk("R7 dcSel", 32'(dcSel), 32'(kind != 0), c);
      if (act && !isRd) chk(cfgWide ? "R11 busOut" : "R8 busOut", 32'(busOut), 32'(expBus), c);
      @(negedge clk);
    end
    if (isRd) begin
      expRd = (16'h5A00 + 16'(int'(cfgAccess) * d + 1));
      if (!cfgWide) expRd = expRd & 32'hFF;
      chk(cfgWide ? "R9 rdData" : "R8 rdData", 32'(rdData), 32'(expRd), -2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int idx;
    reqValid = 1'b0;
    reqKind  = 2'b00;
    reqWdata = '0;
    busIn    = '0;
    cfgDiv2  = 1'b0;
    cfgWide  = 1'b1;
    setCfg(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 csN", 32'(csN), 32'd1, 0);
    chk("R1 wrN", 32'(wrN), 32'd1, 0);
    chk("R1 rdN", 32'(rdN), 32'd1, 0);
    chk("R1 busOe", 32'(busOe), 32'd0, 0);
    chk("R1 busy", 32'(busy), 32'd0, 0);
    chk("R1 rdValid", 32'(rdValid), 32'd0, 0);
    rstN = 1'b1;
    @(negedge clk);
    idx = 0;
    for (int dv = 0; dv < 2; dv++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int s = 0; s < 4; s++) begin
          for (int k = 0; k < 3; k++) begin
            cfgDiv2 = dv[0];
            cfgWide = wd[0];
            setCfg(s);
            runAccess(k, 16'h1234 ^ 16'(idx * 16'h0F1B));
            idx++;
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule